// File: doc/BRIEF.md
# Event Interrupt Status and Enable Registers

This block holds a byte-wide pair of interrupt registers for five event sources: transmit done, receive done, transmit underrun, receive overflow and serial gap received. Single-cycle pulses from the transmit and receive ring engines latch into sticky status bits. Software reads both registers through a byte-wide register port. It clears status bits by writing ones to them and chooses which sources may interrupt by writing the enable register. One level-sensitive interrupt line is raised while any latched source is also enabled.

The five sources sit in the top five bits of each register. The low three bits of both registers always read back as one. The block holds no sequencing state beyond the status and enable flops, so it has no named states. Its only transitions are per-bit ones: set by an event, cleared by a write of one, and held otherwise. Reset is asynchronous and active low.

Top module: `evt_irq_regs`

## Requirements
- R1: While reset is asserted and after it is released, every status and enable bit is zero, both registers read 0x07 and `irq_o` is low.
- R2: A pulse on `evt_pulse[i]` sets status bit 3+i at the next clock edge. The source order from index 0 to 4 is serial gap, receive overflow, transmit underrun, receive done and transmit done. This places transmit done at bit 7, receive done at bit 6, transmit underrun at bit 5, receive overflow at bit 4 and serial gap at bit 3.
- R3: The status register is at offset 0x0C. A write there clears every status bit whose data bit is 1 and leaves every bit whose data bit is 0 unchanged.
- R4: If an event pulse and a clearing write hit the same status bit in the same cycle, the bit stays set.
- R5: The enable register is at offset 0x0D. A write there loads data bits 7:3 into the enables, where 1 enables a source and 0 disables it.
- R6: Bits 2:0 read as 1 at both offsets, whatever data was written.
- R7: `irq_o` is high exactly when some status bit and its matching enable bit are both 1. It follows register changes in the cycle after the edge that made them.
- R8: Status bits latch even when their source is disabled. Enabling such a source later raises `irq_o` without a new event.
- R9: Any other offset reads 0x00, and a write to it changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 5 | Register offset |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| evt_pulse | input | 5 | Event pulses, index 0 serial gap to index 4 transmit done |
| irq_o | output | 1 | Level interrupt |

## Verification
The assertions take inputs to be sampled values on clock edges, with `reg_wr` qualified by `reg_addr` in the same cycle. They treat any number of simultaneous event pulses, together with a write, as legal. They also assume reset is released only between edges. The stimulus drives every input on the falling edge, one cycle at a time, and samples reads shortly after that edge. Pulses last one cycle, and reset is applied and removed on falling edges. The stimulus includes simultaneous multi-source events and an event that collides with a clear of the same bit.

// File: rtl/irq_regs_pkg.sv
package irq_regs_pkg;
    localparam int NUM_SRC  = 5;
    localparam int BYTE_W   = 8;
    localparam int ADDR_W   = 5;
    localparam int SRC_LSB  = BYTE_W - NUM_SRC;
    localparam logic [ADDR_W-1:0] STAT_OFS = 5'h0C;
    localparam logic [ADDR_W-1:0] EN_OFS   = 5'h0D;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_STAT = 2'd1,
        SEL_EN   = 2'd2
    } reg_sel_e;
endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] stat_o
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                stat_o[i] <= 1'b0;
            else if (set_i[i])
                stat_o[i] <= 1'b1;
            else if (clr_i[i])
                stat_o[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_enable_bank.sv
module irq_enable_bank #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [N-1:0] val_i,
    output logic [N-1:0] en_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            en_o <= '0;
        else if (load_i)
            en_o <= val_i;
    end
endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
    import irq_regs_pkg::*;
#(
    parameter int N = NUM_SRC,
    parameter int W = BYTE_W
) (
    input  reg_sel_e     sel_i,
    input  logic [N-1:0] stat_i,
    input  logic [N-1:0] en_i,
    output logic [W-1:0] rdata_o
);
    localparam int FILL = W - N;

    always_comb begin
        unique case (sel_i)
            SEL_STAT: rdata_o = {stat_i, {FILL{1'b1}}};
            SEL_EN:   rdata_o = {en_i,   {FILL{1'b1}}};
            default:  rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/evt_irq_regs.sv
module evt_irq_regs
    import irq_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    input  logic [NUM_SRC-1:0] evt_pulse,
    output logic              irq_o
);
    reg_sel_e           sel;
    logic [NUM_SRC-1:0] wsrc;
    logic [NUM_SRC-1:0] clr;
    logic [NUM_SRC-1:0] stat_q;
    logic [NUM_SRC-1:0] en_q;

    always_comb begin
        if (reg_addr == STAT_OFS)
            sel = SEL_STAT;
        else if (reg_addr == EN_OFS)
            sel = SEL_EN;
        else
            sel = SEL_NONE;
    end

    assign wsrc = reg_wdata[BYTE_W-1:SRC_LSB];
    assign clr  = (reg_wr && sel == SEL_STAT) ? wsrc : '0;

    irq_status_bank #(.N(NUM_SRC)) u_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (evt_pulse),
        .clr_i  (clr),
        .stat_o (stat_q)
    );

    irq_enable_bank #(.N(NUM_SRC)) u_en (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (reg_wr && sel == SEL_EN),
        .val_i  (wsrc),
        .en_o   (en_q)
    );

    irq_read_mux #(.N(NUM_SRC), .W(BYTE_W)) u_rd (
        .sel_i   (sel),
        .stat_i  (stat_q),
        .en_i    (en_q),
        .rdata_o (reg_rdata)
    );

    assign irq_o = |(stat_q & en_q);
endmodule

// File: rtl/evt_irq_regs_chk.sv
module evt_irq_regs_chk
    import irq_regs_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic               reg_wr,
    input logic [BYTE_W-1:0]  reg_wdata,
    input logic [BYTE_W-1:0]  reg_rdata,
    input logic [NUM_SRC-1:0] evt_pulse,
    input logic               irq_o,
    input logic [NUM_SRC-1:0] stat_q,
    input logic [NUM_SRC-1:0] en_q
);
    AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_pulse) |=> ((stat_q & $past(evt_pulse)) == $past(evt_pulse))); // R2
    AST_EVT_WINS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == STAT_OFS && (|(evt_pulse & reg_wdata[BYTE_W-1:SRC_LSB])))
        |=> ((stat_q & $past(evt_pulse)) == $past(evt_pulse))); // R4
    AST_CLEAR_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == STAT_OFS)
        |=> ((stat_q & $past(reg_wdata[BYTE_W-1:SRC_LSB]) & ~$past(evt_pulse)) == '0)); // R3
    AST_STAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == STAT_OFS)
        |=> ((stat_q & $past(stat_q)) == $past(stat_q))); // R3
    AST_EN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == EN_OFS) |=> (en_q == $past(reg_wdata[BYTE_W-1:SRC_LSB]))); // R5
    AST_LOW_BITS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == STAT_OFS || reg_addr == EN_OFS)
        |-> (reg_rdata[SRC_LSB-1:0] == {SRC_LSB{1'b1}})); // R6
    AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (stat_q != '0 && en_q != '0)); // R7
    AST_OTHER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr != STAT_OFS && reg_addr != EN_OFS) |-> (reg_rdata == '0)); // R9
endmodule

bind evt_irq_regs evt_irq_regs_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .evt_pulse (evt_pulse),
    .irq_o     (irq_o),
    .stat_q    (stat_q),
    .en_q      (en_q)
);

// File: tb/sim_evt_irq_regs.sv
`timescale 1ns/1ps
module sim_evt_irq_regs;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] reg_addr = 5'h00;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic [4:0] evt_pulse = 5'h00;
    logic       irq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit ended = 1'b0;

    always #2 clk = ~clk;

    evt_irq_regs u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .evt_pulse (evt_pulse),
        .irq_o     (irq_o)
    );

    // {wr, addr, wdata, evt, check addr, expected rdata, expected irq}
    localparam int NV = 14;
    localparam logic [32:0] VEC [NV] = '{
        {1'b1, 5'h0D, 8'hFF, 5'h00, 5'h0D, 8'hFF, 1'b0}, // R5 enable all
        {1'b0, 5'h00, 8'h00, 5'b10000, 5'h0C, 8'h87, 1'b1}, // R2 tx done bit7
        {1'b0, 5'h00, 8'h00, 5'b00001, 5'h0C, 8'h8F, 1'b1}, // R2 gap bit3
        {1'b1, 5'h0C, 8'h80, 5'h00, 5'h0C, 8'h0F, 1'b1}, // R3 clear bit7
        {1'b1, 5'h0C, 8'h00, 5'h00, 5'h0C, 8'h0F, 1'b1}, // R3 zeros keep
        {1'b1, 5'h0C, 8'h08, 5'b00001, 5'h0C, 8'h0F, 1'b1}, // R4 collision
        {1'b1, 5'h0C, 8'h08, 5'h00, 5'h0C, 8'h07, 1'b0}, // R3 clear gap
        {1'b1, 5'h0D, 8'h00, 5'h00, 5'h0D, 8'h07, 1'b0}, // R6 low bits one
        {1'b0, 5'h00, 8'h00, 5'b01110, 5'h0C, 8'h77, 1'b0}, // R8 latch disabled
        {1'b1, 5'h0D, 8'h20, 5'h00, 5'h0D, 8'h27, 1'b1}, // R7 R8 enable later
        {1'b1, 5'h12, 8'hFF, 5'h00, 5'h12, 8'h00, 1'b1}, // R9 other offset
        {1'b0, 5'h00, 8'h00, 5'h00, 5'h0D, 8'h27, 1'b1}, // R9 enables kept
        {1'b1, 5'h0C, 8'hFF, 5'h00, 5'h0C, 8'h07, 1'b0}, // R3 clear all
        {1'b1, 5'h0D, 8'h07, 5'h00, 5'h0D, 8'h07, 1'b0}  // R6 R5 low data only
    };

    task automatic check8(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
        end
    endtask

    task automatic check1(input string tag, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    task automatic step(input logic w, input logic [4:0] a, input logic [7:0] d, input logic [4:0] e);
        @(negedge clk);
        reg_wr = w; reg_addr = a; reg_wdata = d; evt_pulse = e;
        @(negedge clk);
        reg_wr = 1'b0; evt_pulse = 5'h00;
    endtask

    task automatic look(input logic [4:0] a);
        reg_addr = a;
        #1;
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        #800000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        // R1 during reset
        #1;
        look(5'h0C); check8("R1 stat in reset", reg_rdata, 8'h07);
        look(5'h0D); check8("R1 en in reset", reg_rdata, 8'h07);
        check1("R1 irq in reset", irq_o, 1'b0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        look(5'h0C); check8("R1 stat after reset", reg_rdata, 8'h07);
        check1("R1 irq after reset", irq_o, 1'b0);

        for (int v = 0; v < NV; v++) begin
            logic [32:0] t;
            t = VEC[v];
            step(t[32], t[31:27], t[26:19], t[18:14]);
            look(t[13:9]);
            check8($sformatf("vector %0d rdata (R2-R9 table)", v), reg_rdata, t[8:1]);
            check1($sformatf("vector %0d irq R7", v), irq_o, t[0]);
        end

        // R2 R7: each source on its own
        for (int i = 0; i < 5; i++) begin
            step(1'b1, 5'h0D, 8'(1 << (3 + i)), 5'h00);
            step(1'b1, 5'h0C, 8'hF8, 5'h00);
            look(5'h0C); check1($sformatf("R7 irq idle src %0d", i), irq_o, 1'b0);
            step(1'b0, 5'h00, 8'h00, 5'(1 << i));
            look(5'h0C);
            check8($sformatf("R2 status src %0d", i), reg_rdata, 8'(1 << (3 + i)) | 8'h07);
            check1($sformatf("R7 irq src %0d", i), irq_o, 1'b1);
        end

        // R1 mid-run reset
        step(1'b1, 5'h0D, 8'hF8, 5'h1F);
        look(5'h0C);
        check1("R7 irq before reset", irq_o, 1'b1);
        @(negedge clk); rst_n = 1'b0;
        #1;
        look(5'h0C); check8("R1 stat mid reset", reg_rdata, 8'h07);
        look(5'h0D); check8("R1 en mid reset", reg_rdata, 8'h07);
        check1("R1 irq mid reset", irq_o, 1'b0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        finish_run();
    end
endmodule